// File: doc/BRIEF.md
# TLB refill set hint generator

This block supplies the way-selection hint that a software-refilled MMU reports to the fault handler when a translation fails. It holds a 16-bit linear feedback shift register that acts as a cheap pseudo-random source. On every translation fault it loads a select value. The low bits of that value are the index taken from the faulting virtual page number. The bits above them name a set.

On a true miss, the set is a pseudo-random pick drawn from the shift register. The refill handler then spreads new entries across all ways of the set-associative TLB. On a protection fault the tag did match, so the set field names the way that holds the matching entry. The shift register advances once per fault of either kind and stays still at all other times. TLB storage, the lookup itself and the encoding of the fault cause belong to neighbouring logic.

Top module: `tlb_hint_top`

## Requirements
- R1: After reset `sel_o` is all zeros and the shift register holds 0xCCCC.
- R2: On a fault, `sel_o[3:0]` takes the low 4 bits of `vpn_i`. All bits above bit 5 are zero.
- R3: On a miss (`fault_i`=1, `hit_i`=0), `sel_o[5:4]` takes the two least significant bits of the shift register as they stood before this fault's advance.
- R4: On a protection fault (`fault_i`=1, `hit_i`=1), `sel_o[5:4]` takes `hit_set_i` and the shift register is not consulted.
- R5: Each advance computes the parity of (register AND 0x8805), shifts the register right by one and writes that parity into bit 15. Only 16 bits are kept.
- R6: The register advances exactly once per cycle with `fault_i`=1, for misses and protection faults alike. It does not advance in any other cycle.
- R7: `sel_o` holds its value in every cycle without `fault_i`.
- R8: From reset, the first two miss hints are 0 and then 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_i | input | 1 | Translation fault strobe, one cycle per fault |
| hit_i | input | 1 | Tag matched (protection fault) when 1, miss when 0 |
| hit_set_i | input | 2 | Set of the matching entry |
| vpn_i | input | 19 | Faulting virtual page number |
| sel_o | output | 6 | TLB select value: index in 3:0, set in 5:4 |

## Verification
Every result is due one clock after the strobe. The select value and the advanced shift register are both registered at the edge that samples `fault_i`. A driver pushes the expected select value at the moment it raises the strobe. A monitor notes at that edge that a fault was taken and compares at the next falling edge, away from any edge at which inputs change. Idle cycles between faults are compared at falling edges against the last value, which checks the hold behaviour. A long run of more than 1000 randomly mixed misses and protection faults checks the whole register sequence through the miss hints. Idle gaps within that run check that idle cycles do not advance it.

// File: rtl/tlb_hint_pkg.sv
package tlb_hint_pkg;
  localparam int unsigned LFSR_W  = 16;
  localparam logic [15:0] SEED    = 16'hCCCC;
  localparam logic [15:0] TAPS    = 16'h8805;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned SET_W   = 2;
  localparam int unsigned VPN_W   = 19;
endpackage

// File: rtl/tlb_hint_lfsr.sv
module tlb_hint_lfsr #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] SEED_VAL = '1,
  parameter logic [W-1:0] TAP_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAP_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED_VAL;
    else if (adv_i) state_q <= {fb, state_q[W-1:1]};
  end

  assign state_o = state_q;

  p_idle_still_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
  p_top_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> state_q[W-2:0] == $past(state_q[W-1:1]));
  p_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/tlb_hint_sel.sv
module tlb_hint_sel #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SET_W = 2,
  parameter int unsigned VPN_W = 19,
  localparam int unsigned SEL_W = IDX_W + SET_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             hit_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [SET_W-1:0] rand_set_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [SET_W-1:0] set_pick;

  // protection fault reports the matching way, miss reports the random hint
  assign set_pick = hit_i ? hit_set_i : rand_set_i;

  always_comb begin
    sel_d = '0;
    sel_d[IDX_W-1:0]     = vpn_i[IDX_W-1:0];
    sel_d[SEL_W-1:IDX_W] = set_pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (load_i) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sel_q));
endmodule

// File: rtl/tlb_hint_top.sv
module tlb_hint_top
  import tlb_hint_pkg::*;
#(
  parameter int unsigned LW       = LFSR_W,
  parameter logic [LW-1:0] SEED_V = SEED,
  parameter logic [LW-1:0] TAP_V  = TAPS,
  parameter int unsigned IW       = IDX_W,
  parameter int unsigned SW       = SET_W,
  parameter int unsigned VW       = VPN_W,
  localparam int unsigned OW      = IW + SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fault_i,
  input  logic          hit_i,
  input  logic [SW-1:0] hit_set_i,
  input  logic [VW-1:0] vpn_i,
  output logic [OW-1:0] sel_o
);
  logic [LW-1:0] lfsr_state;

  tlb_hint_lfsr #(.W(LW), .SEED_VAL(SEED_V), .TAP_MASK(TAP_V)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fault_i),
    .state_o(lfsr_state)
  );

  tlb_hint_sel #(.IDX_W(IW), .SET_W(SW), .VPN_W(VW)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (fault_i),
    .hit_i     (hit_i),
    .hit_set_i (hit_set_i),
    .rand_set_i(lfsr_state[SW-1:0]),
    .vpn_i     (vpn_i),
    .sel_o     (sel_o)
  );

  p_index_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> sel_o[IW-1:0] == $past(vpn_i[IW-1:0]));
  p_miss_hint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !hit_i) |=> sel_o[OW-1:IW] == $past(lfsr_state[SW-1:0]));
  p_prot_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && hit_i) |=> sel_o[OW-1:IW] == $past(hit_set_i));
  p_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> lfsr_state != $past(lfsr_state));
endmodule

// File: tb/tlb_hint_top_bench.sv
module tlb_hint_top_bench;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        fault_i = 0;
  logic        hit_i = 0;
  logic [1:0]  hit_set_i = 0;
  logic [18:0] vpn_i = 0;
  logic [5:0]  sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] model = 16'hCCCC;
  logic [5:0]  exp_q[$];
  logic        kind_q[$];
  logic [5:0]  last_sel = 0;
  logic        due = 0;
  logic        mon_on = 0;

  always #10 clk_i = ~clk_i;

  tlb_hint_top u_tlb_hint_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .hit_i(hit_i),
    .hit_set_i(hit_set_i), .vpn_i(vpn_i), .sel_o(sel_o)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return {^(s & 16'h8805), s[15:1]};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_fault(input logic h, input logic [1:0] hs, input logic [18:0] v);
    logic [5:0] e;
    @(negedge clk_i);
    fault_i = 1; hit_i = h; hit_set_i = hs; vpn_i = v;
    e = {(h ? hs : model[1:0]), v[3:0]};
    model = step(model);
    exp_q.push_back(e);
    kind_q.push_back(h);
    @(negedge clk_i);
    fault_i = 0; hit_i = $urandom; hit_set_i = $urandom; vpn_i = $urandom;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  always @(posedge clk_i) due <= fault_i && rst_ni;

  always @(negedge clk_i) begin
    if (mon_on) begin
      if (due) begin
        logic [5:0] e;
        logic k;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        if (k) check("R4 R2", sel_o, e);
        else   check("R3 R5 R6 R2", sel_o, e);
        last_sel = e;
      end else begin
        check("R7", sel_o, last_sel);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", sel_o, 6'h00);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1", sel_o, 6'h00);
    mon_on = 1;
    // R8: first two miss hints from the seed are 0 then 2
    do_fault(0, 2'd3, 19'h7FFF5);
    @(negedge clk_i);
    check("R8", sel_o, 6'h05);
    do_fault(0, 2'd1, 19'h0000A);
    @(negedge clk_i);
    check("R8", sel_o, 6'h2A);
    // R4: protection fault carries the matching set
    do_fault(1, 2'd3, 19'h12347);
    idle(2);
    // R6: protection fault advanced the register; idle cycles did not
    do_fault(0, 2'd0, 19'h00001);
    idle(3);
    do_fault(1, 2'd0, 19'h0000F);
    for (int i = 0; i < 1200; i++) begin
      do_fault(($urandom % 3) == 0, 2'($urandom), 19'($urandom));
      if ((i % 7) == 0) idle(int'($urandom % 3));
    end
    idle(4);
    mon_on = 0;
    // R1: reset mid-run restores seed and clears output
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    check("R1", sel_o, 6'h00);
    rst_ni = 1;
    model = 16'hCCCC;
    last_sel = 0;
    mon_on = 1;
    do_fault(0, 2'd2, 19'h00003);
    do_fault(0, 2'd2, 19'h00004);
    idle(2);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6 act=%0d exp=0 pending results", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule